// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the half-duplex shift-register mode of a microcontroller serial port. It drives a shift clock to an external shift register and exchanges data with it over one data line, split here into a driven value, an output enable and a sampled input. Each bit slot lasts a fixed number of system clocks, twelve by default. Within a slot the data line changes at the start, the shift clock falls partway through and rises two clocks before the slot ends. The external device therefore sees a long setup time and a short hold time around each rising edge.

Software starts a transmit by writing the buffer strobe with a byte. It starts a receive by pulsing the receive-flag clear strobe while reception is enabled. Each transfer moves eight bits, least significant first. At the end it raises a transmit-done or receive-done flag, and that flag stays set until software clears it. The received byte is held in a buffer that software can read while the next transfer runs.

Top module: `sync_shift_port`

## Requirements
- R1: After a clock edge with `rst_n` low, `shclk` is 1, `sd_oe` is 0, `sd_o` is 1, both done flags are 0 and `rx_byte` is 0x00.
- R2: A `wr_buf` pulse while idle starts a transmit in the next cycle. `sd_oe` is high for exactly 96 cycles, and bit i of `wr_data` (i = 0 first) is on `sd_o` for the 12 cycles of slot i.
- R3: During a transfer, `shclk` is low in phases 4 to 9 of each 12-cycle slot (phase 0 = first cycle of the slot) and high in phases 0 to 3, 10 and 11. It stays high whenever no transfer is active.
- R4: `sd_o` changes only in phase 0 of a slot. It is therefore stable for the 10 cycles before each rising edge of `shclk` and for the 2 cycles after it.
- R5: `tx_done` becomes 1 in the cycle after the last cycle of a transmit, 96 cycles after the transfer starts.
- R6: A `clr_rx` pulse with `rx_en` high while idle starts a receive, and `sd_oe` stays 0 throughout. `sd_i` is sampled on the cycle before each rising edge of `shclk`, and the k-th sample goes to bit k (k = 0 first). When the transfer ends, `rx_byte` is updated and `rx_done` is set.
- R7: A `clr_rx` pulse with `rx_en` low clears `rx_done` but starts no transfer: `shclk` stays high.
- R8: A `wr_buf` pulse during an active transfer is ignored. The bits shifted out and the end time are unchanged.
- R9: Each flag stays 1 until its clear strobe (`clr_tx` or `clr_rx`) clears it. If a flag is set and cleared in the same cycle, it becomes 1.
- R10: If `wr_buf` and a valid receive start arrive in the same idle cycle, only the transmit starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_buf | input | 1 | Buffer write strobe, starts a transmit |
| wr_data | input | 8 | Byte to transmit |
| rx_en | input | 1 | Reception enable level |
| clr_tx | input | 1 | Clear strobe for the transmit-done flag |
| clr_rx | input | 1 | Clear strobe for the receive-done flag, starts a receive when enabled |
| sd_i | input | 1 | Serial data from the line |
| sd_o | output | 1 | Serial data driven onto the line |
| sd_oe | output | 1 | Output enable for the data line |
| shclk | output | 1 | Shift clock, idles high |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_byte | output | 8 | Last received byte |

## Verification
The assertions check the line timing on every cycle. The shift clock is high while idle, and it is never low for more than six cycles in a row. The data line holds still while the clock is low and in the cycle after each rising edge. The output enable follows the transfer direction. Each flag rises only as a transfer of its own direction ends, and it holds until it is cleared. The scenarios are needed to show the values: which byte goes out in what order, what byte is assembled from the sampled line, the exact 96-cycle end time, that a write during a transfer is discarded, and how simultaneous starts and set/clear collisions resolve.

// File: rtl/ssp_pkg.sv
// Shared types and default timing constants for the shift-register port.
// Assumes one bit slot is a whole number of system clocks.
package ssp_pkg;
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;

    localparam int SSP_SLOT_CLKS = 12;
    localparam int SSP_FALL_PH   = 4;
    localparam int SSP_RISE_PH   = 10;
    localparam int SSP_NBITS     = 8;
endpackage

// File: rtl/ssp_sequencer.sv
// Transfer sequencer: keeps the slot phase and bit counters, accepts
// start requests only while idle, and produces the registered shift clock.
// Assumes FALL_PH < RISE_PH < SLOT_CLKS so each slot has one low window.
module ssp_sequencer
    import ssp_pkg::*;
#(
    parameter int SLOT_CLKS = SSP_SLOT_CLKS,
    parameter int FALL_PH   = SSP_FALL_PH,
    parameter int RISE_PH   = SSP_RISE_PH,
    parameter int NBITS     = SSP_NBITS
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_tx,
    input  logic      req_rx,
    output logic      go_tx,
    output logic      go_rx,
    output logic      active,
    output xfer_dir_e dir,
    output logic      slot_end,
    output logic      sample_now,
    output logic      xfer_end,
    output logic      shclk
);
    localparam int PH_W  = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam int BIT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(SLOT_CLKS - 1);
    localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(RISE_PH - 1);
    localparam logic [PH_W-1:0]  PH_FALL   = PH_W'(FALL_PH);
    localparam logic [PH_W-1:0]  PH_RISE   = PH_W'(RISE_PH);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(NBITS - 1);

    logic             active_q, active_d;
    xfer_dir_e        dir_q, dir_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic [BIT_W-1:0] bit_q, bit_d;
    logic             shclk_q;

    // Start arbitration: transmit wins, both are refused while busy.
    always_comb begin
        go_tx = req_tx && !active_q;
        go_rx = req_rx && !active_q && !req_tx;
    end

    // Slot event decode from the current phase and bit count.
    always_comb begin
        slot_end   = active_q && (ph_q == PH_LAST);
        sample_now = active_q && (dir_q == DIR_RX) && (ph_q == PH_SAMPLE);
        xfer_end   = slot_end && (bit_q == BIT_LAST);
    end

    // Next-state computation for the phase, bit count and direction.
    always_comb begin
        active_d = active_q;
        dir_d    = dir_q;
        ph_d     = ph_q;
        bit_d    = bit_q;
        if (!active_q) begin
            if (go_tx || go_rx) begin
                active_d = 1'b1;
                dir_d    = go_tx ? DIR_TX : DIR_RX;
                ph_d     = '0;
                bit_d    = '0;
            end
        end else if (xfer_end) begin
            active_d = 1'b0;
            ph_d     = '0;
            bit_d    = '0;
        end else if (slot_end) begin
            ph_d  = '0;
            bit_d = bit_q + 1'b1;
        end else begin
            ph_d = ph_q + 1'b1;
        end
    end

    // State registers; the shift clock is registered from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            dir_q    <= DIR_TX;
            ph_q     <= '0;
            bit_q    <= '0;
            shclk_q  <= 1'b1;
        end else begin
            active_q <= active_d;
            dir_q    <= dir_d;
            ph_q     <= ph_d;
            bit_q    <= bit_d;
            shclk_q  <= !(active_d && (ph_d >= PH_FALL) && (ph_d < PH_RISE));
        end
    end

    assign active = active_q;
    assign dir    = dir_q;
    assign shclk  = shclk_q;
endmodule

// File: rtl/ssp_shifter.sv
// Data path: one shift register serves both directions, shifting right
// so bit 0 leaves first and the first sampled bit lands in bit 0.
// Assumes the sequencer never raises shift and sample in the same cycle
// for a transmit.
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int NBITS = SSP_NBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_tx,
    input  logic             load_rx,
    input  logic [NBITS-1:0] tx_byte,
    input  logic             active,
    input  xfer_dir_e        dir,
    input  logic             slot_end,
    input  logic             sample_now,
    input  logic             xfer_end,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             ser_oe,
    output logic [NBITS-1:0] rx_hold
);
    logic [NBITS-1:0] sh_q;
    logic [NBITS-1:0] hold_q;
    logic             tx_on;

    // Transmit drives the line only while a transmit is in progress.
    always_comb begin
        tx_on   = active && (dir == DIR_TX);
        ser_oe  = tx_on;
        ser_out = tx_on ? sh_q[0] : 1'b1;
    end

    // Shift register: load on start, shift at slot end or on a sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_tx) begin
            sh_q <= tx_byte;
        end else if (load_rx) begin
            sh_q <= '0;
        end else if (sample_now) begin
            sh_q <= {ser_in, sh_q[NBITS-1:1]};
        end else if (slot_end && dir == DIR_TX) begin
            sh_q <= {1'b1, sh_q[NBITS-1:1]};
        end
    end

    // Receive buffer: captures the assembled byte as a receive ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (xfer_end && dir == DIR_RX) begin
            hold_q <= sh_q;
        end
    end

    assign rx_hold = hold_q;
endmodule

// File: rtl/ssp_flags.sv
// Completion flag pair: a flag sets when a transfer of its direction
// ends and clears on its strobe; a set in the same cycle wins.
module ssp_flags
    import ssp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      xfer_end,
    input  xfer_dir_e dir,
    input  logic      clr_tx,
    input  logic      clr_rx,
    output logic      tx_flag,
    output logic      rx_flag
);
    logic tx_q, rx_q;

    // Transmit-done flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          tx_q <= 1'b0;
        else if (xfer_end && dir == DIR_TX)  tx_q <= 1'b1;
        else if (clr_tx)                     tx_q <= 1'b0;
    end

    // Receive-done flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rx_q <= 1'b0;
        else if (xfer_end && dir == DIR_RX)  rx_q <= 1'b1;
        else if (clr_rx)                     rx_q <= 1'b0;
    end

    assign tx_flag = tx_q;
    assign rx_flag = rx_q;
endmodule

// File: rtl/sync_shift_port.sv
// Top of the half-duplex shift-register serial port. It ties the
// sequencer, data path and flags together. Assumes the strobes are
// single-cycle pulses from the register interface.
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int SLOT_CLKS = SSP_SLOT_CLKS,
    parameter int FALL_PH   = SSP_FALL_PH,
    parameter int RISE_PH   = SSP_RISE_PH,
    parameter int NBITS     = SSP_NBITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_buf,
    input  logic [NBITS-1:0] wr_data,
    input  logic             rx_en,
    input  logic             clr_tx,
    input  logic             clr_rx,
    input  logic             sd_i,
    output logic             sd_o,
    output logic             sd_oe,
    output logic             shclk,
    output logic             tx_done,
    output logic             rx_done,
    output logic [NBITS-1:0] rx_byte
);
    logic      go_tx, go_rx, seq_active, slot_end, sample_now, xfer_end;
    xfer_dir_e seq_dir;
    logic      rx_req;

    // Reception request: clearing the flag while reception is enabled.
    always_comb rx_req = clr_rx && rx_en;

    ssp_sequencer #(
        .SLOT_CLKS(SLOT_CLKS), .FALL_PH(FALL_PH),
        .RISE_PH(RISE_PH), .NBITS(NBITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_tx(wr_buf), .req_rx(rx_req),
        .go_tx(go_tx), .go_rx(go_rx), .active(seq_active), .dir(seq_dir),
        .slot_end(slot_end), .sample_now(sample_now),
        .xfer_end(xfer_end), .shclk(shclk)
    );

    ssp_shifter #(.NBITS(NBITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_tx(go_tx), .load_rx(go_rx),
        .tx_byte(wr_data), .active(seq_active), .dir(seq_dir),
        .slot_end(slot_end), .sample_now(sample_now), .xfer_end(xfer_end),
        .ser_in(sd_i), .ser_out(sd_o), .ser_oe(sd_oe), .rx_hold(rx_byte)
    );

    ssp_flags u_flags (
        .clk(clk), .rst_n(rst_n), .xfer_end(xfer_end), .dir(seq_dir),
        .clr_tx(clr_tx), .clr_rx(clr_rx),
        .tx_flag(tx_done), .rx_flag(rx_done)
    );
endmodule

// File: rtl/ssp_checker.sv
// Property checker for the shift-register port, bound to the top module.
module ssp_checker #(
    parameter int LOW_MAX = 6
) (
    input logic clk,
    input logic rst_n,
    input logic active,
    input logic dir_rx,
    input logic shclk,
    input logic sd_o,
    input logic sd_oe,
    input logic tx_done,
    input logic rx_done,
    input logic clr_tx,
    input logic clr_rx
);
    int unsigned low_run;

    // Counts consecutive low cycles of the shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n || shclk) low_run <= 0;
        else                 low_run <= low_run + 1;
    end

    // R3: clock idles high
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> shclk);

    // R3: low window bounded
    a_r3_low_width: assert property (@(posedge clk) disable iff (!rst_n)
        !shclk |-> (low_run < LOW_MAX));

    // R4: data steady while clock low
    a_r4_setup_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!shclk && $past(!shclk)) |-> $stable(sd_o));

    // R4: data held after rising edge
    a_r4_hold_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shclk) |=> $stable(sd_o));

    // R2 / R6: output enable follows direction
    a_r2_oe_tx: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (active && !dir_rx));
    a_r6_oe_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (active && dir_rx) |-> !sd_oe);

    // R5: tx flag rises only at end of a transmit
    a_r5_tx_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> ($past(active) && !$past(dir_rx) && !active));

    // R6: rx flag rises only at end of a receive
    a_r6_rx_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> ($past(active) && $past(dir_rx) && !active));

    // R9: flags hold until cleared
    a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !clr_tx) |=> tx_done);
    a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_rx) |=> rx_done);
endmodule

bind sync_shift_port ssp_checker u_ssp_checker (
    .clk(clk), .rst_n(rst_n), .active(seq_active),
    .dir_rx(seq_dir == ssp_pkg::DIR_RX), .shclk(shclk), .sd_o(sd_o),
    .sd_oe(sd_oe), .tx_done(tx_done), .rx_done(rx_done),
    .clr_tx(clr_tx), .clr_rx(clr_rx)
);

// File: tb/tb_sync_shift_port.sv
module tb_sync_shift_port;
    localparam int CLK_PERIOD = 10;
    localparam int XFER = 96;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_buf = 1'b0, rx_en = 1'b0, clr_tx = 1'b0, clr_rx = 1'b0, sd_i = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic sd_o, sd_oe, shclk, tx_done, rx_done;
    logic [7:0] rx_byte;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit started = 0;

    sync_shift_port dut (
        .clk(clk), .rst_n(rst_n), .wr_buf(wr_buf), .wr_data(wr_data),
        .rx_en(rx_en), .clr_tx(clr_tx), .clr_rx(clr_rx), .sd_i(sd_i),
        .sd_o(sd_o), .sd_oe(sd_oe), .shclk(shclk), .tx_done(tx_done),
        .rx_done(rx_done), .rx_byte(rx_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---- behavioural reference model ----
    int   m_k = -1;
    bit   m_rx = 0, m_txf = 0, m_rxf = 0;
    logic [7:0] m_data = 8'h00, m_buf = 8'h00;
    bit   m_q[$];

    always @(posedge clk) begin
        bit st_tx, st_rx, set_tx, set_rx;
        cyc++;
        started = 1;
        if (!rst_n) begin
            m_k = -1; m_rx = 0; m_txf = 0; m_rxf = 0; m_buf = 8'h00; m_q.delete();
        end else begin
            st_tx = wr_buf && (m_k < 0);
            st_rx = !wr_buf && clr_rx && rx_en && (m_k < 0);
            set_tx = 0; set_rx = 0;
            if (m_k >= 0) begin
                if (m_rx && (m_k % 12) == 9) m_q.push_back(sd_i);
                if (m_k == XFER - 1) begin
                    if (m_rx) begin
                        for (int i = 0; i < 8; i++) m_buf[i] = m_q[i];
                        set_rx = 1;
                    end else set_tx = 1;
                    m_k = -1;
                end else m_k++;
            end else if (st_tx) begin
                m_k = 0; m_rx = 0; m_data = wr_data;
            end else if (st_rx) begin
                m_k = 0; m_rx = 1; m_q.delete();
            end
            if (set_tx) m_txf = 1; else if (clr_tx) m_txf = 0;
            if (set_rx) m_rxf = 1; else if (clr_rx) m_rxf = 0;
        end
    end

    // Per-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        bit e_oe, e_clk, e_o;
        if (started) begin
            e_oe  = (m_k >= 0) && !m_rx;
            e_clk = !((m_k >= 0) && (m_k % 12) >= 4 && (m_k % 12) <= 9);
            e_o   = e_oe ? m_data[m_k / 12] : 1'b1;
            check(shclk === e_clk, "R3 shclk", shclk, e_clk);
            check(sd_oe === e_oe,  "R2 sd_oe", sd_oe, e_oe);
            check(sd_o === e_o,    "R4 sd_o",  sd_o,  e_o);
            check(tx_done === m_txf, "R5 tx_done", tx_done, m_txf);
            check(rx_done === m_rxf, "R6 rx_done", rx_done, m_rxf);
            check(rx_byte === m_buf, "R6 rx_byte", rx_byte, m_buf);
        end
    end

    // Bits captured at each observed rising edge of the shift clock.
    logic [7:0] cap = 8'h00;
    int cap_n = 0;
    logic prev_clk = 1'b1;
    always @(negedge clk) begin
        if (shclk && !prev_clk && sd_oe) begin
            cap[cap_n % 8] = sd_o;
            cap_n++;
        end
        prev_clk = shclk;
    end

    task automatic pulse_wr(input logic [7:0] d);
        wr_data = d; wr_buf = 1'b1;
        @(negedge clk); wr_buf = 1'b0;
    endtask

    task automatic rx_byte_in(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            sd_i = b[i];
            repeat (12) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(shclk === 1'b1 && sd_oe === 1'b0 && sd_o === 1'b1, "R1 line idle", {shclk, sd_oe, sd_o}, 3'b101);
        check(tx_done === 1'b0 && rx_done === 1'b0 && rx_byte === 8'h00, "R1 flags", {tx_done, rx_done, rx_byte}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5: transmit 0xA5, count cycles to flag
        cap_n = 0;
        pulse_wr(8'hA5);
        t = 1;
        while (!tx_done && t < 200) begin @(negedge clk); t++; end
        check(t == XFER + 1, "R5 end time", t, XFER + 1);
        check(cap === 8'hA5 && cap_n == 8, "R2 byte lsb first", cap, 8'hA5);
        repeat (5) @(negedge clk);
        check(tx_done === 1'b1, "R9 flag held", tx_done, 1);
        clr_tx = 1'b1; @(negedge clk); clr_tx = 1'b0;
        check(tx_done === 1'b0, "R9 flag cleared", tx_done, 0);

        // R8: write during transfer ignored
        cap_n = 0;
        pulse_wr(8'h3C);
        repeat (30) @(negedge clk);
        pulse_wr(8'hFF);
        repeat (70) @(negedge clk);
        check(cap === 8'h3C, "R8 mid write ignored", cap, 8'h3C);
        check(tx_done === 1'b1, "R8 end time unchanged", tx_done, 1);
        clr_tx = 1'b1; @(negedge clk); clr_tx = 1'b0;

        // R7: clear with reception disabled starts nothing
        rx_en = 1'b0;
        clr_rx = 1'b1; @(negedge clk); clr_rx = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (i == 10) check(shclk === 1'b1 && sd_oe === 1'b0, "R7 no start", shclk, 1);
            @(negedge clk);
        end

        // R6: receive two bytes
        rx_en = 1'b1;
        clr_rx = 1'b1; @(negedge clk); clr_rx = 1'b0;
        rx_byte_in(8'h96);
        @(negedge clk);
        check(rx_done === 1'b1 && rx_byte === 8'h96, "R6 receive 96", rx_byte, 8'h96);
        clr_rx = 1'b1; @(negedge clk); clr_rx = 1'b0;
        rx_byte_in(8'h01);
        @(negedge clk);
        check(rx_byte === 8'h01, "R6 receive 01", rx_byte, 8'h01);

        // R10: simultaneous write and receive start, transmit wins
        wr_data = 8'h5A; wr_buf = 1'b1; clr_rx = 1'b1;
        @(negedge clk); wr_buf = 1'b0; clr_rx = 1'b0;
        check(sd_oe === 1'b1, "R10 transmit wins", sd_oe, 1);
        check(rx_done === 1'b0, "R10 rx flag cleared", rx_done, 0);
        repeat (XFER) @(negedge clk);
        clr_tx = 1'b1; @(negedge clk); clr_tx = 1'b0;

        // R9: set and clear in the same cycle, set wins
        pulse_wr(8'hC3);
        repeat (XFER - 1) @(negedge clk);
        clr_tx = 1'b1; @(negedge clk); clr_tx = 1'b0;
        check(tx_done === 1'b1, "R9 set beats clear", tx_done, 1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule